// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one non-maskable interrupt input and a parameterised group of external interrupt pins (eight by default). Every input is brought into the core clock domain through a two-stage synchroniser. It is then compared with its previous synchronised sample to find edges. A pin can be armed for falling edges, rising edges, both edges, or a low level. The non-maskable input can be armed for either falling or rising edges. A detected event sets a sticky status bit for that source. Each source drives one request line toward a downstream interrupt distributor. The line is high while the status bit is set and the mask bit for that source is clear.

Software uses a small word-addressed register port. A write takes effect on the clock edge that samples it. A read returns the registered state combinationally, so a read in the cycle after a write shows the value after the write. Status bits for edge sources are cleared by writing zero to them. A clear and a fresh edge in the same cycle leave the bit set. A rewrite of a pin's trigger code throws away any edge seen by that pin in that same cycle. This lets software change the code and then clear the status without a stale edge being recorded.

Top module: `extirq_detect`

## Requirements
- R1: After reset the trigger register (address 0) reads 0: every pin is set to falling edge and the non-maskable input to falling edge. The status register reads 0. The mask register reads all ones over bits 8:0. Every request output is low.
- R2: In the trigger register, pin i owns bits [2i+1:2i]. The codes are 00 falling edge, 01 rising edge, 10 both edges and 11 low level. An edge-mode pin sets its status bit when its synchronised input shows a qualifying edge. The bit becomes visible no later than the third rising clock edge after the pin changes.
- R3: In low-level mode a pin's status bit equals the inverse of its synchronised input. It drops again once the pin returns high.
- R4: Writing the status register (address 1) with a 0 in bit i (bits 7:0 for the pins, bit 8 for the non-maskable input) clears that bit if the source is in an edge mode and the bit is 1. A read in the following cycle returns the cleared value.
- R5: Writing 1 to a status bit leaves that bit unchanged.
- R6: A write to the status bit of a pin in low-level mode has no effect, even when it writes 0.
- R7: The mask register (address 2) holds one bit per source, 1 = masked: pin i is bit i and the non-maskable input is bit 8. A request output is high exactly when its status bit is 1 and its mask bit is 0.
- R8: If a clear write and a qualifying edge for the same source fall in the same cycle, the status bit ends up 1.
- R9: A trigger-register write that changes a source's code discards any edge that source detects in the same cycle.
- R10: Bit 16 of the trigger register selects the non-maskable input's edge (0 falling, 1 rising). Its status bit 8 obeys the same set and clear rules as an edge-mode pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt input, asynchronous |
| irq_pin | input | N_PINS | External interrupt pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 trigger, 1 status, 2 mask) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| nmi_req | output | 1 | Request line for the non-maskable input |
| irq_req | output | N_PINS | Request lines, one per pin |

## Verification
The bench uses the default build: N_PINS = 8 and DATA_W = 32. With these values every 2-bit trigger field, the non-maskable edge select at bit 16 and the status and mask bit 8 all lie inside one data word. This lets the random phase pick any pin and any of the four codes, and compare a single status bit and request line against a model of the edge seen between two pin levels. The default synchroniser depth makes the same-cycle cases reachable with fixed timing. A clear that lands on the cycle of a new edge, and a trigger rewrite that lands on the cycle of a new edge, are both driven on the third clock after the pin toggles.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    typedef enum logic [1:0] {
        TRG_FALL = 2'b00,
        TRG_RISE = 2'b01,
        TRG_BOTH = 2'b10,
        TRG_LOW  = 2'b11
    } trg_mode_e;

    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_TRIG = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd2;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int unsigned W    = 9,
    parameter logic        IDLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.last = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1   <= {W{IDLE}};
            st_q.s2   <= {W{IDLE}};
            st_q.last <= {W{IDLE}};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.s2;
    assign prv = st_q.last;

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    localparam int unsigned TW    = 2 * N_PINS,
    localparam int unsigned NS    = N_PINS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [TW:0]           wdata,
    output logic [TW-1:0]         trig,
    output logic                  nmi_rise,
    output logic [NS-1:0]         mask,
    output logic [NS-1:0]         chg,
    output logic [NS-1:0]         clr
);

    typedef struct packed {
        logic [TW-1:0] trig;
        logic          nmi_rise;
        logic [NS-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic wr_trig, wr_stat, wr_mask;

    always_comb begin
        wr_trig = wr && (addr == ADDR_TRIG);
        wr_stat = wr && (addr == ADDR_STAT);
        wr_mask = wr && (addr == ADDR_MASK);

        cfg_d = cfg_q;
        if (wr_trig) begin
            cfg_d.trig     = wdata[TW-1:0];
            cfg_d.nmi_rise = wdata[TW];
        end
        if (wr_mask) begin
            cfg_d.mask = wdata[NS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.trig     <= '0;
            cfg_q.nmi_rise <= 1'b0;
            cfg_q.mask     <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_chg
        assign chg[g] = wr_trig && (wdata[2*g +: 2] != cfg_q.trig[2*g +: 2]);
    end
    assign chg[N_PINS] = wr_trig && (wdata[TW] != cfg_q.nmi_rise);

    assign clr      = wr_stat ? ~wdata[NS-1:0] : '0;
    assign trig     = cfg_q.trig;
    assign nmi_rise = cfg_q.nmi_rise;
    assign mask     = cfg_q.mask;

    // R1: configuration leaves reset with every source masked
    p_mask_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask == '1));

endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
    import extirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trg_mode_e mode,
    input  logic      cur,
    input  logic      prv,
    input  logic      clr,
    input  logic      mode_chg,
    output logic      status
);

    typedef struct packed {
        logic flag;
    } chan_t;

    chan_t ch_d, ch_q;

    logic rise, fall, hit, lvl;

    always_comb begin
        rise = cur && !prv;
        fall = !cur && prv;
        lvl  = (mode == TRG_LOW);
        unique case (mode)
            TRG_FALL: hit = fall;
            TRG_RISE: hit = rise;
            TRG_BOTH: hit = rise || fall;
            default:  hit = 1'b0;
        endcase

        ch_d = ch_q;
        if (lvl) begin
            ch_d.flag = !cur;
        end else if (hit && !mode_chg) begin
            ch_d.flag = 1'b1;
        end else if (clr && ch_q.flag) begin
            ch_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.flag <= 1'b0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign status = ch_q.flag;

    // R2 and R8: a qualifying edge sets the flag, a same-cycle clear notwithstanding
    p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && hit && !mode_chg) |=> status);

    // R4: a clear on a set edge flag with no new edge drops it
    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && clr && !hit && status) |=> !status);

    // R5: without an edge or a clear the edge flag holds its value
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !hit && !clr) |=> $stable(status));

    // R3 and R6: a high pin in low-level mode leaves the flag clear whatever is written
    p_level_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && cur) |=> !status);

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned TW    = 2 * N_PINS,
    localparam int unsigned NS    = N_PINS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  nmi_pin,
    input  logic [N_PINS-1:0]     irq_pin,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  nmi_req,
    output logic [N_PINS-1:0]     irq_req
);

    logic [NS-1:0] cur, prv;
    logic [TW-1:0] trig;
    logic          nmi_rise;
    logic [NS-1:0] mask, chg, clr, stat;
    logic [DATA_W-TW-2:0] unused_wdata;

    assign unused_wdata = reg_wdata[DATA_W-1:TW+1];

    extirq_sync #(
        .W    (NS),
        .IDLE (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({nmi_pin, irq_pin}),
        .cur   (cur),
        .prv   (prv)
    );

    extirq_regs #(
        .N_PINS (N_PINS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata[TW:0]),
        .trig     (trig),
        .nmi_rise (nmi_rise),
        .mask     (mask),
        .chg      (chg),
        .clr      (clr)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        extirq_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (trg_mode_e'(trig[2*g +: 2])),
            .cur      (cur[g]),
            .prv      (prv[g]),
            .clr      (clr[g]),
            .mode_chg (chg[g]),
            .status   (stat[g])
        );
    end

    extirq_chan u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (nmi_rise ? TRG_RISE : TRG_FALL),
        .cur      (cur[N_PINS]),
        .prv      (prv[N_PINS]),
        .clr      (clr[N_PINS]),
        .mode_chg (chg[N_PINS]),
        .status   (stat[N_PINS])
    );

    assign irq_req = stat[N_PINS-1:0] & ~mask[N_PINS-1:0];
    assign nmi_req = stat[N_PINS] && !mask[N_PINS];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_TRIG: reg_rdata[TW:0]   = {nmi_rise, trig};
            ADDR_STAT: reg_rdata[NS-1:0] = stat;
            ADDR_MASK: reg_rdata[NS-1:0] = mask;
            default:   reg_rdata         = '0;
        endcase
    end

    // R7: no request escapes a set mask bit
    p_mask_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & mask[N_PINS-1:0]) == '0) && !(nmi_req && mask[N_PINS]));

    // R9: a code-changing rewrite never sets a clear edge flag on the same edge
    p_rewrite_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg[N_PINS] && !stat[N_PINS]) |=> !stat[N_PINS]);

endmodule

// File: tb/extirq_detect_bench.sv
module extirq_detect_bench;

    localparam int unsigned NP = 8;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_pin = 1'b1;
    logic [NP-1:0] irq_pin = '1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          nmi_req;
    logic [NP-1:0] irq_req;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    logic [15:0] trig_sh = '0;
    logic        nrise_sh = 1'b0;

    always #10 clk = ~clk;

    extirq_detect #(.N_PINS(NP), .DATA_W(DW)) u_extirq_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_pin   (nmi_pin),
        .irq_pin   (irq_pin),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .nmi_req   (nmi_req),
        .irq_req   (irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(input int p, input logic [1:0] m);
        trig_sh[2*p +: 2] = m;
        wr_reg(2'd0, {15'b0, nrise_sh, trig_sh});
    endtask

    function automatic logic exp_st(input logic [1:0] m, input logic a, input logic b);
        case (m)
            2'b00:   return a && !b;
            2'b01:   return !a && b;
            2'b10:   return a != b;
            default: return !b;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, rv); chk("R1 trigger", rv, 32'h0);
        rd_reg(2'd1, rv); chk("R1 status", rv, 32'h0);
        rd_reg(2'd2, rv); chk("R1 mask", rv, 32'h1FF);
        chk("R1 irq_req", {24'b0, irq_req}, 32'h0);
        chk("R1 nmi_req", {31'b0, nmi_req}, 32'h0);

        wr_reg(2'd2, 32'h0);

        // R2 rising mode on pin 3, R5 write one, R4 clear
        set_mode(3, 2'b01);
        irq_pin[3] = 1'b0; settle();
        rd_reg(2'd1, rv); chk("R2 fall ignored in rise mode", rv, 32'h0);
        irq_pin[3] = 1'b1; settle();
        rd_reg(2'd1, rv); chk("R2 rise sets", rv, 32'h8);
        chk("R2 request", {24'b0, irq_req}, 32'h8);
        wr_reg(2'd1, 32'h1FF);
        rd_reg(2'd1, rv); chk("R5 write one keeps", rv, 32'h8);
        wr_reg(2'd1, 32'h1F7);
        rd_reg(2'd1, rv); chk("R4 clear read back", rv, 32'h0);
        chk("R4 request drops", {24'b0, irq_req}, 32'h0);
        wr_reg(2'd1, 32'h0);
        rd_reg(2'd1, rv); chk("R4 clear of zero bit", rv, 32'h0);

        // R3 and R6 low-level mode on pin 5
        set_mode(5, 2'b11); settle();
        rd_reg(2'd1, rv); chk("R3 high pin clear", rv, 32'h0);
        irq_pin[5] = 1'b0; settle();
        rd_reg(2'd1, rv); chk("R3 low pin sets", rv, 32'h20);
        wr_reg(2'd1, 32'h0);
        rd_reg(2'd1, rv); chk("R6 clear ignored", rv, 32'h20);
        irq_pin[5] = 1'b1; settle();
        rd_reg(2'd1, rv); chk("R3 follows release", rv, 32'h0);

        // R7 masking
        irq_pin[3] = 1'b0; settle();
        irq_pin[3] = 1'b1; settle();
        wr_reg(2'd2, 32'h8);
        rd_reg(2'd1, rv); chk("R7 status kept under mask", rv, 32'h8);
        chk("R7 masked request", {24'b0, irq_req}, 32'h0);
        wr_reg(2'd2, 32'h0);
        chk("R7 unmasked request", {24'b0, irq_req}, 32'h8);
        wr_reg(2'd1, 32'h0);

        // R10 non-maskable input
        nmi_pin = 1'b0; settle();
        rd_reg(2'd1, rv); chk("R10 falling sets", rv, 32'h100);
        chk("R10 nmi_req", {31'b0, nmi_req}, 32'h1);
        wr_reg(2'd2, 32'h100);
        chk("R7 nmi masked", {31'b0, nmi_req}, 32'h0);
        wr_reg(2'd2, 32'h0);
        wr_reg(2'd1, 32'h0FF);
        rd_reg(2'd1, rv); chk("R10 clear", rv, 32'h0);
        nrise_sh = 1'b1;
        wr_reg(2'd0, {15'b0, nrise_sh, trig_sh});
        rd_reg(2'd0, rv); chk("R10 select readback", rv, {15'b0, 1'b1, trig_sh});
        nmi_pin = 1'b1; settle();
        rd_reg(2'd1, rv); chk("R10 rising sets", rv, 32'h100);
        wr_reg(2'd1, 32'h0);
        nmi_pin = 1'b0; settle();
        rd_reg(2'd1, rv); chk("R10 falling ignored", rv, 32'h0);

        // R8 clear and edge in the same cycle
        set_mode(2, 2'b10);
        irq_pin[2] = 1'b0; settle();
        rd_reg(2'd1, rv); chk("R2 both-edge fall", rv, 32'h4);
        irq_pin[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_reg(2'd1, 32'h1FB);
        rd_reg(2'd1, rv); chk("R8 edge wins", rv, 32'h4);
        wr_reg(2'd1, 32'h1FB);
        rd_reg(2'd1, rv); chk("R8 later clear", rv, 32'h0);

        // R9 trigger rewrite on the edge cycle
        set_mode(6, 2'b01);
        irq_pin[6] = 1'b0; settle();
        irq_pin[6] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        set_mode(6, 2'b10);
        rd_reg(2'd1, rv); chk("R9 edge discarded", rv, 32'h0);
        settle();
        rd_reg(2'd1, rv); chk("R9 stays clear", rv, 32'h0);

        // random mix over pins and codes
        for (int it = 0; it < 60; it++) begin
            int unsigned p;
            logic [1:0]  m;
            logic        a, b, mk, e;
            p  = $urandom % NP;
            m  = 2'($urandom);
            a  = 1'($urandom);
            b  = 1'($urandom);
            mk = 1'($urandom);
            irq_pin[p] = a; settle();
            set_mode(int'(p), m);
            wr_reg(2'd1, ~(32'h1 << p));
            wr_reg(2'd2, mk ? (32'h1 << p) : 32'h0);
            rd_reg(2'd1, rv);
            chk((m == 2'b11) ? "R3 random start" : "R4 random clear",
                {31'b0, rv[p]}, {31'b0, (m == 2'b11) ? !a : 1'b0});
            irq_pin[p] = b; settle();
            e = exp_st(m, a, b);
            rd_reg(2'd1, rv);
            chk("R2 random detect", {31'b0, rv[p]}, {31'b0, e});
            chk("R7 random request", {31'b0, irq_req[p]}, {31'b0, e && !mk});
            wr_reg(2'd1, 32'h1FF);
            rd_reg(2'd1, rv);
            chk("R5 random write one", {31'b0, rv[p]}, {31'b0, e});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule